// File: doc/BRIEF.md
# Repeated In-Band Control Code Detector

This block watches the recovered one-bit PDM sample stream of one channel for 8-bit control codes. These codes are silent when decoded as audio. A code turns into an instruction only after the same byte has arrived back to back a minimum number of times. The block finds byte alignment by itself, tracks a one-shot prefix that switches the next code onto a second code page, and counts identical repeats in a saturating counter. It flags any window that matches no code as audio, and it flags runs of identical bits that are too long to be valid PDM.

The downstream power-state logic consumes the event pulse and does not decode the stream itself. While the clock-present flag is low, all internal state is held cleared, so a run of repeats never spans a clock loss.

The framer has two named states. In SEARCH it slides an 8-bit window one bit at a time. On a table match it moves to LOCKED (SEARCH->LOCKED). In LOCKED it checks every eighth bit as a whole frame, and on a frame that matches nothing it drops back (LOCKED->SEARCH). The page tracker also has two named states. NORMAL moves to ARMED when a page-1 code 6 event fires (NORMAL->ARMED). ARMED is consumed and returns to NORMAL when the next different code run begins, or when audio is seen (ARMED->NORMAL).

Top module: `pdm_ctlcode_det`

## Requirements
- R1: After reset, and for as long as `clk_present` is low, `evt_vld`, `audio_seen`, `run_err` and `rep_cnt` are zero, and any repeat run in progress is discarded.
- R2: Codes are framed least significant bit first: the first bit received is bit 0 of the byte. The table is index 1..10 = 0xAA, 0x66, 0xF0, 0x8B, 0x39, 0x56, 0xD1, 0xD2, 0xD4, 0xD8 on both pages.
- R3: Four consecutive copies of 0xAA interpreted on page 1 give one event with `evt_kind`=1 (fast start), `evt_idx`=1 and `evt_pg2`=0. No other code or page gives kind 1.
- R4: The 32nd consecutive copy of an active code gives one event with `evt_kind`=2, the code index and the page in `evt_pg2`, two clock cycles after the strobe of its last bit. On page 1 every index except 7 and 8 is active.
- R5: Reserved codes (page 1 indexes 7 and 8; page 2 all indexes except 3, 9 and 10) advance `rep_cnt` but never produce a kind-2 event.
- R6: A kind-2 event of page-1 index 6 arms page 2 for the next run of a different code only. That run is reported with `evt_pg2`=1, and page-2 kind-2 events exist only for indexes 3, 9 and 10. The run after it is back on page 1.
- R7: A window or locked frame that matches no table byte pulses `audio_seen`, clears `rep_cnt` to 0 and cancels a pending page-2 arming.
- R8: The 64th consecutive copy of any table code, reserved or not, gives one event with `evt_kind`=3.
- R9: `rep_cnt` counts identical consecutive codes. It saturates at 64, and it restarts at 1 when a different code arrives.
- R10: `run_err` pulses once when a run of identical input bits reaches 25 bits. Runs of 24 bits or fewer never pulse it.
- R11: Each of the thresholds 4, 32 and 64 produces at most one event per run of identical codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_present | input | 1 | High while the PDM clock is detected; low clears all state |
| bit_vld | input | 1 | Strobe: `bit_in` carries a new sample this cycle |
| bit_in | input | 1 | Recovered PDM sample of the selected channel |
| evt_vld | output | 1 | One-cycle code event pulse |
| evt_kind | output | 2 | 1 fast start, 2 valid code, 3 sixty-four repeat |
| evt_idx | output | 4 | Code index 1..10 of the event |
| evt_pg2 | output | 1 | Event was interpreted on page 2 |
| rep_cnt | output | 7 | Saturating count of identical consecutive codes |
| audio_seen | output | 1 | Pulse for a window that matches no code |
| run_err | output | 1 | Pulse when a same-bit run reaches 25 |

## Verification
A framer stuck in the wrong state or off by one bit shows up within one frame. Either `audio_seen` pulses on a stream of pure codes, or `rep_cnt` stops at a value other than the number of bytes sent. A page tracker that misses the one-shot behaviour shows up at the next kind-2 event, as a wrong `evt_pg2` or a missing event for a reserved or active code. The sweeps run every table index through both pages and compare counts of each event kind against arithmetic expectations, so a wrong table entry or a wrong threshold becomes visible within 32 bytes.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    localparam int CODE_W = 8;
    localparam int IDX_W  = 4;

    typedef enum logic [1:0] {
        EVK_NONE  = 2'd0,
        EVK_FAST  = 2'd1,
        EVK_VALID = 2'd2,
        EVK_REP   = 2'd3
    } evk_t;

    typedef enum logic {
        FR_SEARCH,
        FR_LOCKED
    } fr_state_t;

    typedef enum logic {
        PG_NORMAL,
        PG_ARMED
    } pg_state_t;

    // Table index of a byte; 0 when the byte is not a control code.
    function automatic logic [IDX_W-1:0] code_index(input logic [CODE_W-1:0] b);
        logic [IDX_W-1:0] r;
        case (b)
            8'hAA:   r = 4'd1;
            8'h66:   r = 4'd2;
            8'hF0:   r = 4'd3;
            8'h8B:   r = 4'd4;
            8'h39:   r = 4'd5;
            8'h56:   r = 4'd6;
            8'hD1:   r = 4'd7;
            8'hD2:   r = 4'd8;
            8'hD4:   r = 4'd9;
            8'hD8:   r = 4'd10;
            default: r = 4'd0;
        endcase
        return r;
    endfunction

    // Whether a code on the given page carries a configuration meaning.
    function automatic logic code_active(input logic pg2, input logic [IDX_W-1:0] idx);
        if (pg2)
            return (idx == 4'd3) || (idx == 4'd9) || (idx == 4'd10);
        else
            return (idx != 4'd0) && (idx != 4'd7) && (idx != 4'd8);
    endfunction

endpackage

// File: rtl/ccd_framer.sv
module ccd_framer
    import ccd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic             frame_vld,
    output logic [IDX_W-1:0] frame_idx,
    output logic             frame_miss
);

    localparam int POS_W = $clog2(CODE_W);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(CODE_W - 1);

    fr_state_t          st_q, st_n;
    logic [CODE_W-2:0]  hist_q;
    logic [POS_W-1:0]   fill_q;
    logic [POS_W-1:0]   pos_q;
    logic [CODE_W-1:0]  win;
    logic [IDX_W-1:0]   widx;
    logic               hit, miss;

    // New bit enters at the top: after eight bits the first one sits in bit 0.
    assign win  = {bit_in, hist_q};
    assign widx = code_index(win);

    always_comb begin
        st_n = st_q;
        hit  = 1'b0;
        miss = 1'b0;
        if (bit_vld) begin
            unique case (st_q)
                FR_SEARCH: begin
                    if (fill_q == LAST_POS) begin
                        if (widx != '0) begin
                            hit  = 1'b1;
                            st_n = FR_LOCKED;
                        end else begin
                            miss = 1'b1;
                        end
                    end
                end
                FR_LOCKED: begin
                    if (pos_q == LAST_POS) begin
                        if (widx != '0) begin
                            hit = 1'b1;
                        end else begin
                            miss = 1'b1;
                            st_n = FR_SEARCH;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= FR_SEARCH;
        else if (clr) st_q <= FR_SEARCH;
        else          st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q     <= '0;
            fill_q     <= '0;
            pos_q      <= '0;
            frame_vld  <= 1'b0;
            frame_idx  <= '0;
            frame_miss <= 1'b0;
        end else if (clr) begin
            hist_q     <= '0;
            fill_q     <= '0;
            pos_q      <= '0;
            frame_vld  <= 1'b0;
            frame_idx  <= '0;
            frame_miss <= 1'b0;
        end else begin
            frame_vld  <= hit;
            frame_miss <= miss;
            if (hit) frame_idx <= widx;
            if (bit_vld) begin
                hist_q <= win[CODE_W-1:1];
                if (fill_q != LAST_POS) fill_q <= fill_q + 1'b1;
                if (st_q == FR_SEARCH) pos_q <= '0;
                else                   pos_q <= pos_q + 1'b1;
            end
        end
    end

    // R2
    frame_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld || frame_miss) |-> $past(bit_vld));

    // R2
    frame_idx_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> (frame_idx >= 4'd1 && frame_idx <= 4'd10));

endmodule

// File: rtl/ccd_repeat.sv
module ccd_repeat
    import ccd_pkg::*;
#(
    parameter int FAST_N  = 4,
    parameter int VALID_N = 32,
    parameter int SAT_N   = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             frame_vld,
    input  logic [IDX_W-1:0]                 frame_idx,
    input  logic                             frame_miss,
    output logic                             evt_vld,
    output evk_t                             evt_kind,
    output logic [IDX_W-1:0]                 evt_idx,
    output logic                             evt_pg2,
    output logic [$clog2(SAT_N+1)-1:0]       rep_cnt
);

    localparam int CNT_W = $clog2(SAT_N + 1);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
    localparam logic [CNT_W-1:0] FAST_C  = CNT_W'(FAST_N);
    localparam logic [CNT_W-1:0] VALID_C = CNT_W'(VALID_N);
    localparam logic [CNT_W-1:0] SAT_C   = CNT_W'(SAT_N);
    localparam logic [IDX_W-1:0] PFX_IDX = 4'd6;

    pg_state_t         pg_q, pg_n;
    logic [CNT_W-1:0]  rep_q, cnt_n;
    logic [IDX_W-1:0]  last_q;
    logic              run_pg_q, pg_use;
    logic              new_run, grow;
    logic              fire_fast, fire_valid, fire_rep;

    always_comb begin
        new_run    = (rep_q == '0) || (frame_idx != last_q);
        cnt_n      = new_run ? ONE_C : ((rep_q == SAT_C) ? SAT_C : rep_q + 1'b1);
        pg_use     = new_run ? (pg_q == PG_ARMED) : run_pg_q;
        grow       = (cnt_n != rep_q);
        fire_fast  = frame_vld && grow && (cnt_n == FAST_C) && !pg_use && (frame_idx == 4'd1);
        fire_valid = frame_vld && grow && (cnt_n == VALID_C) && code_active(pg_use, frame_idx);
        fire_rep   = frame_vld && grow && (cnt_n == SAT_C);
    end

    always_comb begin
        pg_n = pg_q;
        unique case (pg_q)
            PG_NORMAL: if (fire_valid && !pg_use && frame_idx == PFX_IDX) pg_n = PG_ARMED;
            PG_ARMED:  if (frame_miss || (frame_vld && new_run))        pg_n = PG_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pg_q <= PG_NORMAL;
        else if (clr) pg_q <= PG_NORMAL;
        else          pg_q <= pg_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q    <= '0;
            last_q   <= '0;
            run_pg_q <= 1'b0;
            evt_vld  <= 1'b0;
            evt_kind <= EVK_NONE;
            evt_idx  <= '0;
            evt_pg2  <= 1'b0;
        end else if (clr) begin
            rep_q    <= '0;
            last_q   <= '0;
            run_pg_q <= 1'b0;
            evt_vld  <= 1'b0;
            evt_kind <= EVK_NONE;
            evt_idx  <= '0;
            evt_pg2  <= 1'b0;
        end else begin
            evt_vld <= fire_fast || fire_valid || fire_rep;
            if (fire_rep)        evt_kind <= EVK_REP;
            else if (fire_valid) evt_kind <= EVK_VALID;
            else if (fire_fast)  evt_kind <= EVK_FAST;
            else                 evt_kind <= EVK_NONE;
            evt_idx <= frame_idx;
            evt_pg2 <= pg_use;
            if (frame_miss) begin
                rep_q    <= '0;
                run_pg_q <= 1'b0;
            end else if (frame_vld) begin
                rep_q    <= cnt_n;
                last_q   <= frame_idx;
                run_pg_q <= pg_use;
            end
        end
    end

    assign rep_cnt = rep_q;

    // R3
    fast_code1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && evt_kind == EVK_FAST) |-> (evt_idx == 4'd1 && !evt_pg2));

    // R6
    page2_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && evt_kind == EVK_VALID && evt_pg2) |->
        (evt_idx == 4'd3 || evt_idx == 4'd9 || evt_idx == 4'd10));

    // R9
    rep_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_q <= SAT_C);

    // R9
    new_code_restart_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (frame_vld && rep_q != '0 && frame_idx != last_q) |=> (rep_q == ONE_C));

    // R7
    audio_clears_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        frame_miss |=> (rep_q == '0 && pg_q == PG_NORMAL));

    // R11
    evt_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vld |-> $past(frame_vld));

endmodule

// File: rtl/ccd_runlen.sv
module ccd_runlen #(
    parameter int RUN_MAX = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_vld,
    input  logic bit_in,
    output logic run_err
);

    localparam int RL_W = $clog2(RUN_MAX + 2);
    localparam logic [RL_W-1:0] LIM_C = RL_W'(RUN_MAX);
    localparam logic [RL_W-1:0] TOP_C = RL_W'(RUN_MAX + 1);

    logic            prev_q;
    logic [RL_W-1:0] len_q, len_n;

    always_comb begin
        if (len_q == '0 || bit_in != prev_q) len_n = RL_W'(1);
        else if (len_q == TOP_C)             len_n = TOP_C;
        else                                 len_n = len_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            len_q   <= '0;
            run_err <= 1'b0;
        end else if (clr) begin
            prev_q  <= 1'b0;
            len_q   <= '0;
            run_err <= 1'b0;
        end else begin
            run_err <= bit_vld && (len_q == LIM_C) && (len_n == TOP_C);
            if (bit_vld) begin
                prev_q <= bit_in;
                len_q  <= len_n;
            end
        end
    end

    // R10
    err_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_err |-> $past(bit_vld));

    // R10
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_err |=> !run_err);

endmodule

// File: rtl/pdm_ctlcode_det.sv
module pdm_ctlcode_det
    import ccd_pkg::*;
#(
    parameter int FAST_N  = 4,
    parameter int VALID_N = 32,
    parameter int SAT_N   = 64,
    parameter int RUN_MAX = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clk_present,
    input  logic                        bit_vld,
    input  logic                        bit_in,
    output logic                        evt_vld,
    output logic [1:0]                  evt_kind,
    output logic [IDX_W-1:0]            evt_idx,
    output logic                        evt_pg2,
    output logic [$clog2(SAT_N+1)-1:0]  rep_cnt,
    output logic                        audio_seen,
    output logic                        run_err
);

    logic             clr;
    logic             f_vld, f_miss;
    logic [IDX_W-1:0] f_idx;
    evk_t             kind;

    assign clr = !clk_present;

    ccd_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .frame_vld  (f_vld),
        .frame_idx  (f_idx),
        .frame_miss (f_miss)
    );

    ccd_repeat #(
        .FAST_N  (FAST_N),
        .VALID_N (VALID_N),
        .SAT_N   (SAT_N)
    ) u_repeat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .frame_vld  (f_vld),
        .frame_idx  (f_idx),
        .frame_miss (f_miss),
        .evt_vld    (evt_vld),
        .evt_kind   (kind),
        .evt_idx    (evt_idx),
        .evt_pg2    (evt_pg2),
        .rep_cnt    (rep_cnt)
    );

    ccd_runlen #(
        .RUN_MAX (RUN_MAX)
    ) u_runlen (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .run_err (run_err)
    );

    assign evt_kind   = kind;
    assign audio_seen = f_miss;

    // R1
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_present |=> (!evt_vld && !audio_seen && !run_err && rep_cnt == '0));

endmodule

// File: tb/sim_pdm_ctlcode_det.sv
module sim_pdm_ctlcode_det;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_present = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       evt_vld;
    logic [1:0] evt_kind;
    logic [3:0] evt_idx;
    logic       evt_pg2;
    logic [6:0] rep_cnt;
    logic       audio_seen;
    logic       run_err;

    int n_chk = 0;
    int n_bad = 0;
    int fcnt = 0, vcnt = 0, rcnt = 0, aud_n = 0, err_n = 0;
    int lv_idx = 0, lv_pg = 0, lr_idx = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pdm_ctlcode_det u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_present (clk_present),
        .bit_vld     (bit_vld),
        .bit_in      (bit_in),
        .evt_vld     (evt_vld),
        .evt_kind    (evt_kind),
        .evt_idx     (evt_idx),
        .evt_pg2     (evt_pg2),
        .rep_cnt     (rep_cnt),
        .audio_seen  (audio_seen),
        .run_err     (run_err)
    );

    always @(negedge clk) begin
        if (evt_vld) begin
            case (evt_kind)
                2'd1: fcnt++;
                2'd2: begin vcnt++; lv_idx = int'(evt_idx); lv_pg = int'(evt_pg2); end
                2'd3: begin rcnt++; lr_idx = int'(evt_idx); end
                default: ;
            endcase
        end
        if (audio_seen) aud_n++;
        if (run_err) err_n++;
    end

    function automatic logic [7:0] code_byte(input int idx);
        case (idx)
            1: return 8'hAA;  2: return 8'h66;  3: return 8'hF0;
            4: return 8'h8B;  5: return 8'h39;  6: return 8'h56;
            7: return 8'hD1;  8: return 8'hD2;  9: return 8'hD4;
            default: return 8'hD8;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic send_rep(input logic [7:0] b, input int n);
        for (int k = 0; k < n; k++) send_byte(b);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic drop_clock();
        @(negedge clk);
        clk_present = 1'b0;
        repeat (3) @(negedge clk);
        clk_present = 1'b1;
        settle();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int f0, v0, r0, a0, e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clk_present = 1'b1;
        settle();

        // R1 reset state
        chk("R1 rep_cnt after reset", int'(rep_cnt), 0);
        chk("R1 no events after reset", fcnt + vcnt + rcnt + aud_n + err_n, 0);

        // R3 R4 R8 R9 R11: one long run of 0xAA
        send_rep(8'hAA, 4);
        settle();
        chk("R3 fast event at 4", fcnt, 1);
        chk("R9 rep_cnt at 4", int'(rep_cnt), 4);
        send_rep(8'hAA, 28);
        settle();
        chk("R4 valid event at 32", vcnt, 1);
        chk("R4 valid idx", lv_idx, 1);
        send_rep(8'hAA, 38);
        settle();
        chk("R8 repeat event at 64", rcnt, 1);
        chk("R9 rep_cnt saturates", int'(rep_cnt), 64);
        chk("R11 one event per threshold", fcnt + vcnt + rcnt, 3);

        // R2 R4 R5: page-1 sweep of every index
        for (int idx = 1; idx <= 10; idx++) begin
            drop_clock();
            f0 = fcnt; v0 = vcnt;
            send_rep(code_byte(idx), 32);
            settle();
            chk("R4 page1 rep_cnt", int'(rep_cnt), 32);
            chk("R5 page1 valid count", vcnt - v0, (idx == 7 || idx == 8) ? 0 : 1);
            chk("R3 fast only code1", fcnt - f0, (idx == 1) ? 1 : 0);
            if (idx != 7 && idx != 8) begin
                chk("R2 page1 valid idx", lv_idx, idx);
                chk("R2 page1 flag", lv_pg, 0);
            end
        end

        // R6 R5: page-2 sweep through the prefix
        for (int idx = 1; idx <= 10; idx++) begin
            int back;
            if (idx == 6) continue;
            drop_clock();
            send_rep(8'h56, 32);
            settle();
            chk("R6 prefix event idx", lv_idx, 6);
            f0 = fcnt; v0 = vcnt;
            send_rep(code_byte(idx), 32);
            settle();
            chk("R6 page2 valid count", vcnt - v0,
                (idx == 3 || idx == 9 || idx == 10) ? 1 : 0);
            chk("R3 no fast on page2", fcnt - f0, 0);
            if (idx == 3 || idx == 9 || idx == 10) begin
                chk("R6 page2 flag", lv_pg, 1);
                chk("R6 page2 idx", lv_idx, idx);
            end
            back = (idx == 3) ? 2 : 3;
            send_rep(code_byte(back), 32);
            settle();
            chk("R6 back to page1 flag", lv_pg, 0);
            chk("R6 back to page1 idx", lv_idx, back);
        end

        // R9 different code restarts at 1
        drop_clock();
        send_rep(8'hAA, 10);
        send_rep(8'h66, 3);
        settle();
        chk("R9 restart on new code", int'(rep_cnt), 3);

        // R7 audio clears count
        a0 = aud_n;
        send_byte(8'h01);
        settle();
        chk("R7 audio clears rep_cnt", int'(rep_cnt), 0);
        chk("R7 audio_seen pulsed", (aud_n > a0) ? 1 : 0, 1);

        // R7 audio cancels page-2 arming
        drop_clock();
        send_rep(8'h56, 32);
        send_byte(8'h01);
        send_rep(8'hF0, 32);
        settle();
        chk("R7 arming cancelled idx", lv_idx, 3);
        chk("R7 arming cancelled flag", lv_pg, 0);

        // R5 R8 reserved code still gives 64 event
        drop_clock();
        v0 = vcnt; r0 = rcnt;
        send_rep(8'hD1, 64);
        settle();
        chk("R5 reserved no valid", vcnt - v0, 0);
        chk("R8 reserved 64 event", rcnt - r0, 1);
        chk("R8 reserved 64 idx", lr_idx, 7);

        // R1 clock loss discards a run
        drop_clock();
        v0 = vcnt;
        send_rep(8'hAA, 20);
        drop_clock();
        chk("R1 rep_cnt cleared by clock loss", int'(rep_cnt), 0);
        send_rep(8'hAA, 12);
        settle();
        chk("R1 run restarted", int'(rep_cnt), 12);
        chk("R1 no valid event across loss", vcnt - v0, 0);

        // R10 run-length error
        drop_clock();
        e0 = err_n;
        for (int i = 0; i < 25; i++) send_bit(1'b0);
        settle();
        chk("R10 error at 25 zeros", err_n - e0, 1);
        for (int i = 0; i < 24; i++) send_bit(1'b1);
        send_bit(1'b0);
        settle();
        chk("R10 no error at 24 ones", err_n - e0, 1);
        for (int i = 0; i < 30; i++) send_bit(1'b1);
        settle();
        chk("R10 single error per run", err_n - e0, 2);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule